// File: doc/BRIEF.md
# Serial Port Register File with Prioritised Interrupt

This block is the host-facing register set of a 16550-style serial port. A host reaches it through a byte-wide access port with eight register offsets. Each access completes in a single cycle. The block holds the control registers (interrupt enable, line control, modem control, scratch and the baud divisor), a receive queue, and the modem status flags. From these it derives one interrupt cause by fixed priority, and it drives a level interrupt line from that cause.

Received characters arrive on a valid/ready stream. The block accepts a byte in a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low while the queue is at capacity, or while the host writes the FIFO control offset. In loopback mode `rx_ready` stays high and line bytes are dropped. Bytes that the host writes to the data offset leave on a transmit stream as a single-cycle `tx_valid` pulse. The transmitter always accepts, so that stream has no ready.

The register access contract is as follows. `bus_rdata` is valid combinationally in a cycle where `bus_req` is high and `bus_we` is low. Writes, and all read side effects, take effect at the clock edge that ends that cycle, and only if `bus_req` is high. Offsets 0 to 7 are decoded as follows:
- 0: data, or divisor low byte.
- 1: interrupt enable, or divisor high byte.
- 2: interrupt identification on read, FIFO control on write.
- 3: line control.
- 4: modem control.
- 5: line status.
- 6: modem status.
- 7: scratch.

Line control bit 7 selects the divisor bytes at offsets 0 and 1.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the registers read as follows: interrupt enable 0x00, line control 0x00, modem control 0x00, scratch 0x00, line status 0x60, modem status 0x00 and identification 0x01. `irq` is low. The divisor reads low byte 12 and high byte 0.
- R2: While line control bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. The data register, the interrupt enable register and the transmit stream are untouched.
- R3: An interrupt enable write keeps only bits 3:0, and the upper bits read as 0. Modem control keeps bits 4:0. Line control and scratch keep all 8 bits.
- R4: The identification code is chosen by the first match in this order:
  - 0x06: overrun flag set and enable bit 2 set.
  - 0x0C: queue not empty and enable bit 0 set.
  - 0x02: transmit-empty pending and enable bit 1 set.
  - 0x00: any modem delta bit set and enable bit 3 set.
  - 0x01: none of the above.
- R5: `irq` is high exactly when the current identification code is not 0x01.
- R6: A data write outside divisor mode sets transmit-empty pending. When not in loopback, it also pulses `tx_valid` with the byte on `tx_data` in the same cycle. An identification read that returns 0x02 clears the pending flag.
- R7: While the FIFO is enabled, identification reads have bits 7:6 set. FIFO control bit 0 is the enable.
- R8: A line status read returns the following bits, all other bits 0:
  - bit 6 = 1 and bit 5 = 1 (transmitter always empty).
  - bit 0 = queue not empty.
  - bit 1 = overrun.
  The overrun bit is cleared by that read.
- R9: The queue holds 1 byte while the FIFO is disabled and FIFO_DEPTH bytes while it is enabled. Changing the enable bit flushes the queue. Writing FIFO control with bits 0 and 1 both set also flushes it. A data read pops bytes in arrival order.
- R10: Modem control bit 4 selects loopback. In loopback:
  - Data writes enter the queue.
  - A data write to a full queue sets overrun and drops the byte.
  - Line bytes are accepted and discarded.
- R11: A modem control write in loopback mirrors four bits into modem status: bit 1 to bit 4, bit 0 to bit 5, bit 2 to bit 6 and bit 3 to bit 7. Outside loopback those status bits are 0. The modem status delta bits record changes:
  - bit 0: bit 4 changed.
  - bit 1: bit 5 changed.
  - bit 3: bit 7 changed.
  - bit 2: bit 6 fell.
  The delta bits are sticky until a modem status read clears them.
- R12: Writes to line status and modem status are ignored. Reads outside offsets 0 to 7 return 0xFF. A data read of an empty queue returns 0xFF.
- R13: Read side effects (pop, overrun clear, delta clear, pending clear) occur only in a cycle with `bus_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Received byte accepted when valid is high |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmitted byte pulse |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and ADDR_W = 4. The shallow queue lets the bench fill it, hit back-pressure and overflow it in loopback within a few accesses. The wider address brings offsets 8 to 15 into reach for the 0xFF readback. This configuration also makes an exhaustive sweep practical: all 16 combinations of the four interrupt conditions are crossed with all 16 enable values, and each expected code is computed from the priority rule. Further full sweeps cover every byte value of the writable registers and every loopback modem control pattern. In the modem control sweep, the expected deltas are derived from the previous and the new values.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  // interrupt enable bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef enum logic [3:0] {
    CAUSE_MODEM = 4'h0,
    CAUSE_NONE  = 4'h1,
    CAUSE_THRE  = 4'h2,
    CAUSE_LINE  = 4'h6,
    CAUSE_RX    = 4'hC
  } cause_e;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         deep_mode,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = deep_mode ? (count == CAP) : !empty;
  assign head  = store[rp];

  always_ff @(posedge clk) begin
    if (push && !flush) store[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [4:0] ctl_new,
  input  logic       stat_rd,
  output logic [7:0] stat
);
  // level order: [0]=cts [1]=dsr [2]=ri [3]=dcd
  logic [3:0] level_q, level_d;
  // delta order: [0]=cts chg [1]=dsr chg [2]=ri fell [3]=dcd chg
  logic [3:0] delta_q, delta_new;

  always_comb begin
    level_d   = {4{ctl_new[4]}} & {ctl_new[3], ctl_new[2], ctl_new[0], ctl_new[1]};
    delta_new = {level_d[3] ^ level_q[3],
                 level_q[2] & ~level_d[2],
                 level_d[1] ^ level_q[1],
                 level_d[0] ^ level_q[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      delta_q <= '0;
    end else if (ctl_wr) begin
      level_q <= level_d;
      delta_q <= delta_q | delta_new;
    end else if (stat_rd) begin
      delta_q <= '0;
    end
  end

  assign stat = {level_q, delta_q};

  assert_delta_clear_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ctl_wr) |=> (stat[3:0] == 4'h0));
  assert_loop_off_levels_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_new[4]) |=> (stat[7:4] == 4'h0));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_rf_pkg::*;
(
  input  logic [3:0] enable,
  input  logic       overrun,
  input  logic       rx_avail,
  input  logic       thre_pend,
  input  logic       modem_delta,
  output cause_e     cause,
  output logic       active
);
  always_comb begin
    if (overrun && enable[EN_LINE])            cause = CAUSE_LINE;
    else if (rx_avail && enable[EN_RX])        cause = CAUSE_RX;
    else if (thre_pend && enable[EN_THRE])     cause = CAUSE_THRE;
    else if (modem_delta && enable[EN_MODEM])  cause = CAUSE_MODEM;
    else                                       cause = CAUSE_NONE;
  end
  assign active = (cause != CAUSE_NONE);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_RESET  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  localparam logic [15:0] DIV_INIT = 16'(DIV_RESET);

  logic [3:0] ier_q;
  logic [7:0] lcr_q, scr_q, dll_q, dlh_q;
  logic [4:0] mcr_q;
  logic       fifo_en_q, oe_q, thre_q;

  // address window
  logic in_win;
  generate
    if (ADDR_W > 3) begin : g_wide
      assign in_win = (bus_addr[ADDR_W-1:3] == '0);
    end else begin : g_exact
      assign in_win = 1'b1;
    end
  endgenerate

  logic [2:0] ofs;
  logic dlab, loop, wr_ok, rd_ok, sel_dl;
  assign ofs    = bus_addr[2:0];
  assign dlab   = lcr_q[7];
  assign loop   = mcr_q[4];
  assign wr_ok  = bus_req &  bus_we & in_win;
  assign rd_ok  = bus_req & ~bus_we & in_win;
  assign sel_dl = dlab & ((ofs == OFS_DATA) | (ofs == OFS_IER));

  logic data_wr, data_rd, ier_wr, fcr_wr, iir_rd, lcr_wr, mcr_wr;
  logic lsr_rd, msr_rd, scr_wr, dll_wr, dlh_wr;
  assign data_wr = wr_ok & ~sel_dl & (ofs == OFS_DATA);
  assign data_rd = rd_ok & ~sel_dl & (ofs == OFS_DATA);
  assign ier_wr  = wr_ok & ~sel_dl & (ofs == OFS_IER);
  assign dll_wr  = wr_ok & dlab & (ofs == OFS_DATA);
  assign dlh_wr  = wr_ok & dlab & (ofs == OFS_IER);
  assign fcr_wr  = wr_ok & (ofs == OFS_IIR);
  assign iir_rd  = rd_ok & (ofs == OFS_IIR);
  assign lcr_wr  = wr_ok & (ofs == OFS_LCR);
  assign mcr_wr  = wr_ok & (ofs == OFS_MCR);
  assign lsr_rd  = rd_ok & (ofs == OFS_LSR);
  assign msr_rd  = rd_ok & (ofs == OFS_MSR);
  assign scr_wr  = wr_ok & (ofs == OFS_SCR);

  // receive queue
  logic       ff_push, ff_pop, ff_flush, ff_full, ff_empty;
  logic [7:0] ff_pdata, ff_head;
  logic       lb_push, lb_ovf, line_push;

  assign lb_push   = data_wr & loop & ~ff_full;
  assign lb_ovf    = data_wr & loop &  ff_full;
  assign rx_ready  = loop | (~ff_full & ~fcr_wr);
  assign line_push = rx_valid & rx_ready & ~loop;
  assign ff_push   = lb_push | line_push;
  assign ff_pdata  = loop ? bus_wdata : rx_data;
  assign ff_pop    = data_rd & ~ff_empty;
  assign ff_flush  = fcr_wr & ((bus_wdata[0] != fifo_en_q) | (bus_wdata[0] & bus_wdata[1]));

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(ff_flush), .deep_mode(fifo_en_q),
    .push(ff_push), .push_data(ff_pdata), .pop(ff_pop),
    .head(ff_head), .full(ff_full), .empty(ff_empty)
  );

  // modem status
  logic [7:0] msr;
  uart_modem_status u_modem (
    .clk(clk), .rst_n(rst_n), .ctl_wr(mcr_wr), .ctl_new(bus_wdata[4:0]),
    .stat_rd(msr_rd), .stat(msr)
  );

  // interrupt cause
  cause_e cause;
  logic   cause_on;
  uart_irq_prio u_prio (
    .enable(ier_q), .overrun(oe_q), .rx_avail(~ff_empty), .thre_pend(thre_q),
    .modem_delta(|msr[3:0]), .cause(cause), .active(cause_on)
  );
  assign irq = cause_on;

  // transmit stream
  assign tx_valid = data_wr & ~loop;
  assign tx_data  = bus_wdata;

  // register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q     <= '0;
      lcr_q     <= '0;
      mcr_q     <= '0;
      scr_q     <= '0;
      dll_q     <= DIV_INIT[7:0];
      dlh_q     <= DIV_INIT[15:8];
      fifo_en_q <= 1'b0;
      oe_q      <= 1'b0;
      thre_q    <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= bus_wdata[3:0];
      if (lcr_wr) lcr_q <= bus_wdata;
      if (mcr_wr) mcr_q <= bus_wdata[4:0];
      if (scr_wr) scr_q <= bus_wdata;
      if (dll_wr) dll_q <= bus_wdata;
      if (dlh_wr) dlh_q <= bus_wdata;
      if (fcr_wr) fifo_en_q <= bus_wdata[0];
      if (lb_ovf)      oe_q <= 1'b1;
      else if (lsr_rd) oe_q <= 1'b0;
      if (data_wr)                            thre_q <= 1'b1;
      else if (iir_rd && cause == CAUSE_THRE) thre_q <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = 8'hFF;
    if (in_win) begin
      if (sel_dl) begin
        bus_rdata = (ofs == OFS_DATA) ? dll_q : dlh_q;
      end else begin
        case (ofs)
          OFS_DATA: bus_rdata = ff_empty ? 8'hFF : ff_head;
          OFS_IER:  bus_rdata = {4'h0, ier_q};
          OFS_IIR:  bus_rdata = {{2{fifo_en_q}}, 2'b00, cause};
          OFS_LCR:  bus_rdata = lcr_q;
          OFS_MCR:  bus_rdata = {3'b000, mcr_q};
          OFS_LSR:  bus_rdata = {1'b0, 1'b1, 1'b1, 3'b000, oe_q, ~ff_empty};
          OFS_MSR:  bus_rdata = msr;
          default:  bus_rdata = scr_q;
        endcase
      end
    end
  end

  assert_ier_low_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier_q == $past(bus_wdata[3:0])));
  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == 4'h0) |-> !irq);
  assert_thre_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> thre_q);
  assert_oe_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd |=> !oe_q);
  assert_lb_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lb_ovf |=> oe_q);
  assert_no_side_effect_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> ($stable(oe_q) && $stable(thre_q)));
  assert_divisor_mode_no_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dlab |-> !tx_valid);
endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic       tx_valid, irq;
  logic [7:0] tx_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] q;
  bit acc;
  logic tx_seen;
  logic [7:0] tx_seen_d;

  always #10 clk = ~clk;

  uart_regfile #(.ADDR_W(4), .FIFO_DEPTH(4), .DIV_RESET(12)) i_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a[3:0]; bus_wdata = d;
    #2; tx_seen = tx_valid; tx_seen_d = tx_data;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] r);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a[3:0];
    #2; r = bus_rdata;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic idle(input int a);
    @(negedge clk);
    bus_req = 0; bus_addr = a[3:0];
    @(posedge clk); #1;
  endtask

  task automatic rxp(input logic [7:0] d, output bit ok);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    #2; ok = rx_ready;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  function automatic logic [7:0] exp_iir(bit ov, bit rx, bit th, bit md, logic [3:0] ie);
    if (ov && ie[2]) return 8'h06;
    if (rx && ie[0]) return 8'h0C;
    if (th && ie[1]) return 8'h02;
    if (md && ie[3]) return 8'h00;
    return 8'h01;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk({7'b0, irq}, 8'h00, "R1 irq");
    rd(1, q); chk(q, 8'h00, "R1 ier");
    rd(2, q); chk(q, 8'h01, "R1 iir");
    rd(3, q); chk(q, 8'h00, "R1 lcr");
    rd(4, q); chk(q, 8'h00, "R1 mcr");
    rd(5, q); chk(q, 8'h60, "R1 lsr");
    rd(6, q); chk(q, 8'h00, "R1 msr");
    rd(7, q); chk(q, 8'h00, "R1 scr");
    wr(3, 8'h80);
    rd(0, q); chk(q, 8'd12, "R1 div low");
    rd(1, q); chk(q, 8'h00, "R1 div high");

    // R2 divisor sweep
    for (int v = 0; v < 256; v++) begin
      wr(0, 8'(v)); chk({7'b0, tx_seen}, 8'h00, "R2 no tx in divisor mode");
      wr(1, ~8'(v));
      rd(0, q); chk(q, 8'(v), "R2 div low");
      rd(1, q); chk(q, ~8'(v), "R2 div high");
    end
    wr(3, 8'h00);
    rd(1, q); chk(q, 8'h00, "R2 ier untouched");
    rd(5, q); chk(q, 8'h60, "R2 queue untouched");

    // R3 register sweeps
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v)); rd(1, q); chk(q, 8'(v) & 8'h0F, "R3 ier mask");
      wr(7, 8'(v)); rd(7, q); chk(q, 8'(v), "R3 scratch");
      wr(3, 8'(v)); rd(3, q); chk(q, 8'(v), "R3 lcr");
      wr(3, 8'h00);
      wr(4, 8'(v)); rd(4, q); chk(q, 8'(v) & 8'h1F, "R3 mcr mask");
    end

    // R4 R5 priority sweep over conditions x enables
    for (int c = 0; c < 16; c++) begin
      for (int ie = 0; ie < 16; ie++) begin
        do_reset();
        if (c[0]) begin
          wr(4, 8'h10); wr(0, 8'h55); wr(0, 8'h66); rd(0, q);
          wr(4, 8'h00); wr(1, 8'h02); rd(2, q); wr(1, 8'h00);
        end
        if (c[3]) begin wr(4, 8'h12); wr(4, 8'h00); end
        if (c[1]) rxp(8'h3A, acc);
        if (c[2]) wr(0, 8'h21);
        wr(1, 8'(ie));
        chk({7'b0, irq}, {7'b0, exp_iir(c[0], c[1], c[2], c[3], 4'(ie)) != 8'h01}, "R5 irq level");
        rd(2, q); chk(q, exp_iir(c[0], c[1], c[2], c[3], 4'(ie)), "R4 cause code");
      end
    end

    // R6 transmit-empty pending
    do_reset();
    wr(1, 8'h02);
    chk({7'b0, irq}, 8'h00, "R6 idle irq");
    wr(0, 8'h3C);
    chk({7'b0, tx_seen}, 8'h01, "R6 tx pulse");
    chk(tx_seen_d, 8'h3C, "R6 tx data");
    chk({7'b0, irq}, 8'h01, "R6 irq set");
    rd(2, q); chk(q, 8'h02, "R6 thre code");
    rd(2, q); chk(q, 8'h01, "R6 pending cleared");
    chk({7'b0, irq}, 8'h00, "R6 irq clear");

    // R12 ignored writes and unmapped reads
    wr(5, 8'hFF); rd(5, q); chk(q, 8'h60, "R12 lsr write ignored");
    wr(6, 8'hFF); rd(6, q); chk(q, 8'h00, "R12 msr write ignored");
    for (int a = 8; a < 16; a++) begin
      rd(a, q); chk(q, 8'hFF, "R12 unmapped");
    end
    rd(0, q); chk(q, 8'hFF, "R12 empty data read");

    // R7 R9 FIFO mode
    do_reset();
    wr(2, 8'h01);
    rd(2, q); chk(q, 8'hC1, "R7 fifo bits");
    for (int i = 0; i < 4; i++) begin
      rxp(8'hA0 + 8'(i), acc); chk({7'b0, acc}, 8'h01, "R9 accept");
    end
    rxp(8'hAF, acc); chk({7'b0, acc}, 8'h00, "R9 backpressure");
    rd(5, q); chk(q, 8'h61, "R8 data ready");
    wr(1, 8'h01);
    chk({7'b0, irq}, 8'h01, "R5 rx irq");
    rd(2, q); chk(q, 8'hCC, "R7 rx code in fifo mode");
    for (int i = 0; i < 4; i++) begin
      rd(0, q); chk(q, 8'hA0 + 8'(i), "R9 order");
    end
    rd(0, q); chk(q, 8'hFF, "R12 empty after drain");
    rd(5, q); chk(q, 8'h60, "R8 empty lsr");
    rxp(8'h01, acc); rxp(8'h02, acc);
    wr(2, 8'h03);
    rd(5, q); chk(q, 8'h60, "R9 rx reset flush");
    rxp(8'h03, acc); rxp(8'h04, acc);
    wr(2, 8'h00);
    rd(5, q); chk(q, 8'h60, "R9 disable flush");
    rd(2, q); chk(q, 8'h01, "R7 bits clear when disabled");
    rxp(8'h05, acc); chk({7'b0, acc}, 8'h01, "R9 single slot accept");
    rxp(8'h06, acc); chk({7'b0, acc}, 8'h00, "R9 single slot full");
    rd(0, q); chk(q, 8'h05, "R9 single slot data");

    // R10 R8 R13 loopback overflow
    do_reset();
    wr(4, 8'h10); wr(2, 8'h01);
    for (int i = 0; i < 5; i++) begin
      wr(0, 8'h11 + 8'(i)); chk({7'b0, tx_seen}, 8'h00, "R10 no tx in loopback");
    end
    rxp(8'h99, acc); chk({7'b0, acc}, 8'h01, "R10 line byte taken");
    idle(5); idle(0);
    rd(5, q); chk(q, 8'h63, "R13 oe kept over idle, R8 oe set");
    rd(5, q); chk(q, 8'h61, "R8 oe cleared by read");
    for (int i = 0; i < 4; i++) begin
      rd(0, q); chk(q, 8'h11 + 8'(i), "R10 loopback order");
    end
    rd(0, q); chk(q, 8'hFF, "R10 line byte discarded");

    // R11 modem status loopback sweep
    do_reset();
    begin
      logic [3:0] prev;
      prev = 4'h0;
      for (int m = 0; m < 16; m++) begin
        logic [3:0] lv, dl;
        lv = {m[3], m[2], m[0], m[1]};
        dl = {lv[3] ^ prev[3], prev[2] & ~lv[2], lv[1] ^ prev[1], lv[0] ^ prev[0]};
        wr(4, 8'h10 | 8'(m));
        idle(6);
        rd(6, q); chk(q, {lv, dl}, "R11 status and deltas");
        rd(6, q); chk(q, {lv, 4'h0}, "R11 deltas cleared");
        prev = lv;
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule